// File: doc/BRIEF.md
# Receive Frame Checker with Cleared-on-Read Status

This block sits on the receive side of an Ethernet data link controller, after the destination-address filter. Every frame the filter lets through arrives as a byte stream marked with first-byte and last-byte flags. The block measures the frame length and runs a CRC-32 over all of it, frame check sequence included. It then writes the frame bytes towards a receive FIFO, with a ninth bit that marks the final byte written. It also records a one-byte receive result that software reads and retires.

The result register acts as a one-deep mailbox. While a result has not been read, any frame that starts is thrown away whole. The first read of a fresh result flags it as stale. The block drives one interrupt line. That line combines the receive result, masked by a receive command register, with a transmit result that comes in from outside, masked by a transmit command register. A ready output stays high while at least one complete frame is waiting in the FIFO. The consumer pulses a pop input when it reads a frame's final byte. Frames must be separated by at least one idle cycle.

Top module: `rx_frame_checker`

## Requirements
- R1: When reset is released, `rx_status` reads 0x80 (stale flag bit 7 set), `irq`, `rx_ready` and `fifo_we` are low, and both command registers hold zero.
- R2: When the last byte of an accepted frame is taken, `rx_status` changes on the next cycle to bit 4 (end of frame) plus one class bit, with bit 7 clear. The class bit is bit 3 (short) if the frame totals fewer than 64 bytes. Otherwise it is bit 1 (CRC error) if the CRC-32 register after the last byte differs from 0xDEBB20E3. Otherwise it is bit 5 (good). The CRC is reflected, uses polynomial 0xEDB88320, is preset to all ones and takes each byte LSB first.
- R3: A frame whose first byte arrives while bit 7 of `rx_status` is clear is discarded whole: it causes no FIFO writes, and `rx_status` keeps the earlier result.
- R4: If receive command bit 6 is 0 when a frame starts, its final 4 bytes are never written. Every earlier byte is written once, in order, on `fifo_wdata[7:0]`, each one 4 input bytes later. Bit 8 is set only on the last byte written. A frame of 4 bytes or fewer writes nothing.
- R5: If receive command bit 6 is 1 when a frame starts, every byte is written, each one input byte later. The final byte is written in the cycle after the last input byte and carries bit 8.
- R6: A `status_rd` pulse sets bit 7 of `rx_status` on the next cycle. If a frame result is committed in the same cycle, the commit wins and bit 7 stays clear.
- R7: `rx_ready` is high exactly while the number of final-byte writes exceeds the number of `fifo_pop_last` pulses. It rises in the cycle the final-byte write appears. A write and a pop in the same cycle cancel.
- R8: `irq` is registered. It is high one cycle after this holds: (`rx_status` bit 7 clear and `rx_status[5:0]` AND receive command bits 5:0 nonzero) or (`tx_status_i` bit 7 clear and `tx_status_i[5:0]` AND transmit command bits 5:0 nonzero).
- R9: A `cmd_we` pulse writes `cmd_wdata` into the receive command register when `cmd_sel` is 0, or into the transmit command register when it is 1. The new value takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A frame byte is present |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of its frame |
| in_eof | input | 1 | Byte is the last of its frame |
| cmd_we | input | 1 | Command register write strobe |
| cmd_sel | input | 1 | 0 selects receive command, 1 transmit command |
| cmd_wdata | input | 8 | Command value |
| status_rd | input | 1 | Software reads the receive result |
| tx_status_i | input | 8 | Transmit result byte, bit 7 = stale |
| fifo_pop_last | input | 1 | Consumer read a frame's final byte |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_wdata | output | 9 | Bit 8 last-byte marker, bits 7:0 data |
| rx_ready | output | 1 | At least one complete frame is in the FIFO |
| rx_status | output | 8 | Receive result byte |
| irq | output | 1 | Combined masked interrupt |

## Verification
Two pairs of events can land on the same clock edge, and the bench provokes both. A status read is issued on the very cycle that an accepted frame's last byte is taken, so the read and the commit meet; the new result must stand with bit 7 clear. A pop pulse is issued on the edge where another frame's final-byte write is registered, so `rx_ready` must stay high with the count unchanged. Each clock, a behavioural model built from queues judges both outcomes.

// File: rtl/rxchk_pkg.sv
package rxchk_pkg;
  typedef logic [7:0] byte_t;

  localparam int unsigned ST_OVF   = 0;
  localparam int unsigned ST_CRC   = 1;
  localparam int unsigned ST_DRIB  = 2;
  localparam int unsigned ST_SHORT = 3;
  localparam int unsigned ST_EOF   = 4;
  localparam int unsigned ST_GOOD  = 5;
  localparam int unsigned ST_OLD   = 7;
  localparam int unsigned CMD_KEEP = 6;
  localparam int unsigned MASK_W   = 6;

  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET  = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input byte_t d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/rxchk_crc.sv
module rxchk_crc
  import rxchk_pkg::*;
#(
  parameter int unsigned MIN_FRAME = 64
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  take,
  input  logic  first,
  input  byte_t data,
  output logic  short_o,
  output logic  residue_ok_o
);
  localparam int unsigned LEN_W = $clog2(MIN_FRAME + 1);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MIN_FRAME);

  logic [31:0]      crc_q, crc_n;
  logic [LEN_W-1:0] len_q, len_n;

  always_comb begin
    crc_n = crc_step(first ? CRC_PRESET : crc_q, data);
    if (first)               len_n = LEN_W'(1);
    else if (len_q == LEN_CAP) len_n = len_q;
    else                     len_n = len_q + LEN_W'(1);
  end

  assign short_o      = (len_n < LEN_CAP);
  assign residue_ok_o = (crc_n == CRC_RESIDUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= CRC_PRESET;
      len_q <= '0;
    end else if (take) begin
      crc_q <= crc_n;
      len_q <= len_n;
    end
  end
endmodule

// File: rtl/rxchk_strip.sv
module rxchk_strip
  import rxchk_pkg::*;
#(
  parameter int unsigned HOLD = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       take,
  input  logic       first,
  input  logic       last,
  input  logic       keep_cmd,
  input  byte_t      data,
  output logic       we_o,
  output logic [8:0] wdata_o,
  output logic       commit_o
);
  byte_t           sr [HOLD];
  logic [HOLD-1:0] sv;
  logic            keep_q, flush_q;
  logic            keep_now, tap_v, emit, we_n;
  byte_t           tap_d;
  logic [8:0]      wd_n;

  assign keep_now = first ? keep_cmd : keep_q;
  assign tap_v    = keep_now ? sv[0] : sv[HOLD-1];
  assign tap_d    = keep_now ? sr[0] : sr[HOLD-1];
  assign emit     = take && !first && tap_v;

  always_comb begin
    we_n = 1'b0;
    wd_n = '0;
    if (flush_q) begin
      we_n = 1'b1;
      wd_n = {1'b1, sr[0]};
    end else if (emit) begin
      we_n = 1'b1;
      wd_n = {last && !keep_now, tap_d};
    end
  end

  assign commit_o = we_n && wd_n[8];

  always_ff @(posedge clk) begin
    if (rst) sr[0] <= '0;
    else if (take) sr[0] <= data;
  end

  for (genvar i = 1; i < HOLD; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) sr[i] <= '0;
      else if (take) sr[i] <= sr[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sv      <= '0;
      keep_q  <= 1'b0;
      flush_q <= 1'b0;
      we_o    <= 1'b0;
      wdata_o <= '0;
    end else begin
      if (take) sv <= first ? HOLD'(1) : {sv[HOLD-2:0], 1'b1};
      if (take && first) keep_q <= keep_cmd;
      flush_q <= take && last && keep_now;
      we_o    <= we_n;
      wdata_o <= wd_n;
    end
  end
endmodule

// File: rtl/rxchk_status.sv
module rxchk_status
  import rxchk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic              is_short,
  input  logic              residue_ok,
  input  logic              rd,
  input  logic [MASK_W-1:0] rx_mask,
  input  byte_t             tx_stat,
  input  logic [MASK_W-1:0] tx_mask,
  output byte_t             stat_o,
  output logic              irq_o
);
  byte_t cls;
  logic  irq_n;

  always_comb begin
    cls = '0;
    cls[ST_EOF]   = 1'b1;
    cls[ST_SHORT] = is_short;
    cls[ST_CRC]   = !is_short && !residue_ok;
    cls[ST_GOOD]  = !is_short && residue_ok;
  end

  assign irq_n = (!stat_o[ST_OLD] && |(stat_o[MASK_W-1:0] & rx_mask)) ||
                 (!tx_stat[ST_OLD] && |(tx_stat[MASK_W-1:0] & tx_mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_o <= 8'h80;
      irq_o  <= 1'b0;
    end else begin
      if (commit)  stat_o <= cls;
      else if (rd) stat_o[ST_OLD] <= 1'b1;
      if (irq_n != irq_o) irq_o <= irq_n;
    end
  end
endmodule

// File: rtl/rx_frame_checker.sv
module rx_frame_checker
  import rxchk_pkg::*;
#(
  parameter int unsigned FCS_BYTES = 4,
  parameter int unsigned MIN_FRAME = 64,
  parameter int unsigned PEND_W    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic       cmd_we,
  input  logic       cmd_sel,
  input  logic [7:0] cmd_wdata,
  input  logic       status_rd,
  input  logic [7:0] tx_status_i,
  input  logic       fifo_pop_last,
  output logic       fifo_we,
  output logic [8:0] fifo_wdata,
  output logic       rx_ready,
  output logic [7:0] rx_status,
  output logic       irq
);
  byte_t             rx_cmd, tx_cmd;
  logic              accept_q, take, is_short, residue_ok, commit_last;
  logic [PEND_W-1:0] pend_q, pend_n;

  assign take = in_valid && (in_sof ? rx_status[ST_OLD] : accept_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_cmd   <= '0;
      tx_cmd   <= '0;
      accept_q <= 1'b0;
    end else begin
      if (cmd_we && !cmd_sel) rx_cmd <= cmd_wdata;
      if (cmd_we &&  cmd_sel) tx_cmd <= cmd_wdata;
      if (in_valid && in_sof) accept_q <= rx_status[ST_OLD];
    end
  end

  rxchk_crc #(.MIN_FRAME(MIN_FRAME)) u_crc (
    .clk(clk), .rst(rst), .take(take), .first(in_sof), .data(in_data),
    .short_o(is_short), .residue_ok_o(residue_ok)
  );

  rxchk_strip #(.HOLD(FCS_BYTES)) u_strip (
    .clk(clk), .rst(rst), .take(take), .first(in_sof), .last(in_eof),
    .keep_cmd(rx_cmd[CMD_KEEP]), .data(in_data),
    .we_o(fifo_we), .wdata_o(fifo_wdata), .commit_o(commit_last)
  );

  rxchk_status u_status (
    .clk(clk), .rst(rst), .commit(take && in_eof), .is_short(is_short),
    .residue_ok(residue_ok), .rd(status_rd), .rx_mask(rx_cmd[MASK_W-1:0]),
    .tx_stat(tx_status_i), .tx_mask(tx_cmd[MASK_W-1:0]),
    .stat_o(rx_status), .irq_o(irq)
  );

  assign pend_n = pend_q + PEND_W'(commit_last) - PEND_W'(fifo_pop_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      rx_ready <= 1'b0;
    end else begin
      pend_q   <= pend_n;
      rx_ready <= (pend_n != '0);
    end
  end
endmodule

// File: rtl/rxchk_checker.sv
module rxchk_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_eof,
  input logic       status_rd,
  input logic [7:0] tx_status_i,
  input logic       fifo_we,
  input logic [8:0] fifo_wdata,
  input logic       rx_ready,
  input logic [7:0] rx_status,
  input logic       irq
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (rx_status == 8'h80 && !irq && !rx_ready && !fifo_we));

  p_one_class_r2: assert property (@(posedge clk) disable iff (rst)
    !rx_status[7] |-> (rx_status[4] && $countones(rx_status & 8'h2A) == 1));

  p_unread_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (!rx_status[7] && !status_rd) |=> $stable(rx_status));

  p_read_marks_old_r6: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !(in_valid && in_eof)) |=> rx_status[7]);

  p_last_write_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (fifo_we && fifo_wdata[8]) |-> rx_ready);

  p_stale_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(rx_status[7]) && $past(tx_status_i[7]) && !$past(rst)) |-> !irq);
endmodule

bind rx_frame_checker rxchk_checker u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_eof(in_eof),
  .status_rd(status_rd), .tx_status_i(tx_status_i), .fifo_we(fifo_we),
  .fifo_wdata(fifo_wdata), .rx_ready(rx_ready), .rx_status(rx_status), .irq(irq)
);

// File: tb/rx_frame_checker_test.sv
`timescale 1ns/1ps
module rx_frame_checker_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = 0;
  logic cmd_we = 0, cmd_sel = 0;
  logic [7:0] cmd_wdata = 0;
  logic status_rd = 0, fifo_pop_last = 0;
  logic [7:0] tx_status_i = 8'h80;
  logic fifo_we, rx_ready, irq;
  logic [8:0] fifo_wdata;
  logic [7:0] rx_status;

  int vectors = 0, fails = 0;
  bit started = 0, done = 0;

  always #2 clk = ~clk;

  rx_frame_checker uut (.*);

  // behavioural reference state
  logic [7:0] m_stat, m_rxcmd, m_txcmd;
  logic m_irq, m_ready, m_we, m_acc, m_keep, m_flush;
  logic [8:0] m_wd;
  logic [7:0] m_fbyte;
  int m_pend;
  logic [7:0] m_q[$];

  function automatic logic [31:0] crc_of(input logic [7:0] b[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (b[k]) begin
      c = c ^ {24'h0, b[k]};
      for (int s = 0; s < 8; s++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  always @(posedge clk) begin
    logic n_irq, we, commit, inc;
    logic [8:0] wd;
    logic [7:0] nstat;
    int j;
    started <= 1;
    if (rst) begin
      m_stat = 8'h80; m_rxcmd = 0; m_txcmd = 0; m_irq = 0; m_ready = 0;
      m_we = 0; m_wd = 0; m_acc = 0; m_keep = 0; m_flush = 0; m_pend = 0;
      m_q.delete();
    end else begin
      n_irq = (!m_stat[7] && |(m_stat[5:0] & m_rxcmd[5:0])) ||
              (!tx_status_i[7] && |(tx_status_i[5:0] & m_txcmd[5:0]));
      we = 0; wd = 0; commit = 0; nstat = m_stat;
      if (m_flush) begin we = 1; wd = {1'b1, m_fbyte}; m_flush = 0; end
      if (in_valid) begin
        if (in_sof) begin m_acc = m_stat[7]; m_keep = m_rxcmd[6]; m_q.delete(); end
        if (m_acc) begin
          m_q.push_back(in_data);
          j = m_q.size() - 1;
          if (m_keep) begin
            if (j >= 1) begin we = 1; wd = {1'b0, m_q[j-1]}; end
            if (in_eof) begin m_flush = 1; m_fbyte = in_data; end
          end else if (j >= 4) begin
            we = 1; wd = {in_eof, m_q[j-4]};
          end
          if (in_eof) begin
            commit = 1;
            if (m_q.size() < 64) nstat = 8'h18;
            else if (crc_of(m_q) == 32'hDEBB20E3) nstat = 8'h30;
            else nstat = 8'h12;
          end
        end
      end
      if (commit) m_stat = nstat;
      else if (status_rd) m_stat[7] = 1'b1;
      if (cmd_we && !cmd_sel) m_rxcmd = cmd_wdata;
      if (cmd_we && cmd_sel) m_txcmd = cmd_wdata;
      inc = we && wd[8];
      m_pend = m_pend + int'(inc) - int'(fifo_pop_last);
      m_ready = (m_pend != 0);
      m_we = we; m_wd = wd; m_irq = n_irq;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(rx_status === m_stat, rst ? "R1 status" : "R2/R3/R6 status", 16'(rx_status), 16'(m_stat));
      chk(fifo_we === m_we, rst ? "R1 fifo_we" : "R3/R4/R5 fifo_we", 16'(fifo_we), 16'(m_we));
      if (m_we) chk(fifo_wdata === m_wd, "R4/R5 fifo_wdata", 16'(fifo_wdata), 16'(m_wd));
      chk(rx_ready === m_ready, rst ? "R1 rx_ready" : "R7 rx_ready", 16'(rx_ready), 16'(m_ready));
      chk(irq === m_irq, rst ? "R1 irq" : "R8/R9 irq", 16'(irq), 16'(m_irq));
    end
  end

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eof = 0; status_rd = 0; fifo_pop_last = 0; cmd_we = 0;
    end
  endtask

  task automatic wcmd(input logic sel, input logic [7:0] v);
    @(negedge clk); cmd_we = 1; cmd_sel = sel; cmd_wdata = v;
    idle(1);
  endtask

  task automatic rd_status();
    @(negedge clk); status_rd = 1;
    idle(2);
  endtask

  task automatic pop();
    @(negedge clk); fifo_pop_last = 1;
    idle(2);
  endtask

  // n = total bytes; n >= 8 gets a computed FCS (corrupted when bad)
  task automatic send(input int n, input bit bad, input int seed, input int rd_at, input int pop_at);
    logic [7:0] fr[$];
    logic [31:0] f;
    if (n >= 8) begin
      for (int i = 0; i < n - 4; i++) fr.push_back(8'((seed + i) * 7 + 3));
      f = ~crc_of(fr);
      if (bad) f = f ^ 32'h0000_0100;
      for (int i = 0; i < 4; i++) fr.push_back(f[8*i +: 8]);
    end else begin
      for (int i = 0; i < n; i++) fr.push_back(8'(seed + i * 13));
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = fr[i]; in_sof = (i == 0); in_eof = (i == n - 1);
      status_rd = (i == rd_at); fifo_pop_last = (i == pop_at); cmd_we = 0;
    end
    idle(3);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    idle(4);
    @(negedge clk); rst = 0;
    idle(3);                               // R1 reset state compared every cycle
    wcmd(0, 8'h3A); wcmd(1, 8'h01);        // R9 masks: crc, short, eof, good; strip
    send(70, 0, 1, -1, -1); idle(2);       // R2 good, R4 strip, R8 irq
    send(80, 0, 9, -1, -1);                // R3 dropped: result unread
    rd_status(); pop();                    // R6, R7
    send(64, 1, 4, 63, -1);                // R2 crc error, R6 read meets commit
    rd_status(); pop();
    wcmd(0, 8'h7A);                        // R5 keep FCS
    send(20, 0, 5, -1, -1); rd_status(); pop();   // R2 short
    send(70, 0, 6, -1, -1); rd_status(); pop();
    wcmd(0, 8'h3A);
    send(3, 0, 2, -1, -1); rd_status();    // R4 tiny frame writes nothing
    send(70, 0, 7, -1, -1); rd_status();
    send(66, 0, 8, -1, 65);                // R7 pop meets final write
    rd_status(); pop();
    @(negedge clk); tx_status_i = 8'h01; idle(3);  // R8 transmit side
    @(negedge clk); tx_status_i = 8'h81; idle(3);
    wcmd(0, 8'h00);
    send(70, 0, 3, -1, -1); idle(2); rd_status(); pop();  // R8 masked
    idle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule